// File: doc/BRIEF.md
# SCSI Controller Interrupt-Status Register Bank

This block holds the three registers that host software reads when a SCSI bus controller raises an interrupt: a status byte (bus phase, terminal-count flag, interrupt-pending flag), a sequence-step value and an interrupt-cause byte. The host reads them in the order status, sequence step, interrupt cause. Reading the interrupt-cause register acknowledges the interrupt.

A completion event from the target side normally loads all three registers in one clock. If an earlier interrupt is still unacknowledged, the event is parked in a single holding slot and the registers are left alone. After the host has read the interrupt-cause register, the parked event is applied on the following clock. Every triple the host reads therefore describes one event, even when a completion lands in the middle of the host's read sequence. A DMA terminal-count input sets the terminal-count flag on its own. The transfer-count, FIFO and command offsets belong to other blocks and read as zero here.

Top module: `isr_bank`

## Requirements
- R1: A synchronous reset clears phase, terminal count, sequence step, interrupt cause and the holding slot, and it drives `irq` low. All three registers then read 0x00.
- R2: A completion applied with no interrupt pending loads the phase field (status bits [2:0]) from `cmpl_phase`, sets terminal count (status 0x10), sets the sequence step to 0 and sets the interrupt cause to bus service (0x10). If a clearing read of the interrupt register falls on the same edge, the completion takes priority.
- R3: `irq` and status bit 0x80 are high exactly while the interrupt-cause register is nonzero. Status bits 0x40, 0x20 and 0x08 always read 0.
- R4: A read at offset 0x5 returns the interrupt cause and, on the same edge, clears it, clears terminal count and sets the sequence step to 0x4. Read data appears on `reg_rdata` in the cycle after the read strobe.
- R5: A completion that arrives while the interrupt cause is nonzero is stored in the holding slot, and the status, sequence and interrupt registers stay unchanged.
- R6: A held completion is applied on the clock edge after the one that cleared the interrupt cause, which raises `irq` again. The slot then empties, so the event is applied only once.
- R7: If several completions arrive while an interrupt is pending, the last one is kept (default `DEFER_LATEST`=1).
- R8: A `tc_hit` pulse sets status bit 0x10 and changes nothing else.
- R9: Reads at 0x4 (status) and 0x6 (sequence step) have no side effects. Reads at any other offset except 0x5 return 0 and have no side effects.
- R10: Writes to 0x4, 0x5 and 0x6 are ignored.
- R11: A completion on the same edge as a clearing read of 0x5 is held, because the interrupt was still pending at that edge. The read returns the old cause.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_addr | input | 4 | Register offset |
| reg_rd | input | 1 | Read strobe, one cycle |
| reg_wr | input | 1 | Write strobe, one cycle |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after `reg_rd` |
| cmpl_valid | input | 1 | Completion event strobe |
| cmpl_phase | input | 3 | Phase code carried by the completion |
| tc_hit | input | 1 | DMA terminal-count pulse |
| irq | output | 1 | Interrupt request, active high |

## Verification
Completions, `tc_hit` and read side effects change the registers at the rising edge on which they are sampled, so `irq` is checked at the next falling edge. Read data is captured at the strobe's edge and is checked one falling edge after the strobe is driven. A held completion is due exactly one edge later than the clearing read. For that case the bench checks that `irq` is low at the falling edge just after the read and high at the falling edge after that. All stimulus is driven on falling edges, so each check falls in a known half cycle.

// File: rtl/isr_pkg.sv
package isr_pkg;

   // interrupt cause encodings
   localparam logic [7:0] CAUSE_FUNC_DONE = 8'h08;
   localparam logic [7:0] CAUSE_BUS_SVC   = 8'h10;
   localparam logic [7:0] CAUSE_DISCON    = 8'h20;
   localparam logic [7:0] CAUSE_BUS_RST   = 8'h80;

   // status byte bit positions
   localparam int STAT_TC_BIT  = 4;
   localparam int STAT_PE_BIT  = 5;
   localparam int STAT_GE_BIT  = 6;
   localparam int STAT_INT_BIT = 7;

   // phase codes
   localparam logic [2:0] PH_DATA_OUT = 3'd0;
   localparam logic [2:0] PH_DATA_IN  = 3'd1;
   localparam logic [2:0] PH_COMMAND  = 3'd2;
   localparam logic [2:0] PH_STATUS   = 3'd3;
   localparam logic [2:0] PH_MSG_OUT  = 3'd6;
   localparam logic [2:0] PH_MSG_IN   = 3'd7;

   // sequence step values
   localparam logic [2:0] STEP_IDLE = 3'd0;
   localparam logic [2:0] STEP_ACK  = 3'd4;

   typedef struct packed {
      logic       vld;
      logic [2:0] phase;
   } cmpl_evt_t;

endpackage

// File: rtl/isr_defer.sv
module isr_defer
   import isr_pkg::*;
#(
   parameter int PHASE_W      = 3,
   parameter bit DEFER_LATEST = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               cmpl_valid,
   input  logic [PHASE_W-1:0] cmpl_phase,
   input  logic               pend,
   output logic               apply_vld,
   output logic [PHASE_W-1:0] apply_phase,
   output logic               held_q
);

   logic [PHASE_W-1:0] held_phase_q;
   logic               release_now;
   logic               store_now;
   logic [PHASE_W-1:0] store_phase;

   assign release_now = held_q && !pend;
   assign store_now   = cmpl_valid && (pend || release_now);
   assign apply_vld   = release_now || (cmpl_valid && !pend);
   assign apply_phase = release_now ? held_phase_q : cmpl_phase;

   generate
      if (DEFER_LATEST) begin : g_latest
         assign store_phase = cmpl_phase;
      end else begin : g_first
         assign store_phase = (held_q && !release_now) ? held_phase_q : cmpl_phase;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         held_q       <= 1'b0;
         held_phase_q <= '0;
      end else if (store_now) begin
         held_q       <= 1'b1;
         held_phase_q <= store_phase;
      end else if (release_now) begin
         held_q       <= 1'b0;
      end
   end

   // R5
   hold_on_pend_chk: assert property (@(posedge clk) disable iff (rst)
      (pend && cmpl_valid) |=> held_q);

   // R6
   release_once_chk: assert property (@(posedge clk) disable iff (rst)
      (held_q && !pend && !cmpl_valid) |=> !held_q);

endmodule

// File: rtl/isr_regs.sv
module isr_regs
   import isr_pkg::*;
#(
   parameter int PHASE_W = 3,
   parameter int SEQ_W   = 3,
   parameter int CAUSE_W = 8
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               apply_vld,
   input  logic [PHASE_W-1:0] apply_phase,
   input  logic               rd_cause,
   input  logic               tc_hit,
   output logic [PHASE_W-1:0] phase_q,
   output logic               tc_q,
   output logic [SEQ_W-1:0]   seq_q,
   output logic [CAUSE_W-1:0] cause_q
);

   localparam logic [SEQ_W-1:0]   SEQ_ACK  = SEQ_W'(STEP_ACK);
   localparam logic [SEQ_W-1:0]   SEQ_IDLE = SEQ_W'(STEP_IDLE);
   localparam logic [CAUSE_W-1:0] CAUSE_BS = CAUSE_W'(CAUSE_BUS_SVC);

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= '0;
         tc_q    <= 1'b0;
         seq_q   <= '0;
         cause_q <= '0;
      end else begin
         if (rd_cause) begin
            cause_q <= '0;
            tc_q    <= 1'b0;
            seq_q   <= SEQ_ACK;
         end
         if (tc_hit) begin
            tc_q <= 1'b1;
         end
         if (apply_vld) begin
            phase_q <= apply_phase;
            tc_q    <= 1'b1;
            seq_q   <= SEQ_IDLE;
            cause_q <= CAUSE_BS;
         end
      end
   end

   // R2
   cmpl_load_chk: assert property (@(posedge clk) disable iff (rst)
      apply_vld |=> (cause_q == CAUSE_BS && tc_q && seq_q == SEQ_IDLE
                     && phase_q == $past(apply_phase)));

   // R4
   ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_cause && !apply_vld && !tc_hit) |=> (cause_q == '0 && !tc_q && seq_q == SEQ_ACK));

   // R8
   tc_set_chk: assert property (@(posedge clk) disable iff (rst)
      (tc_hit && !apply_vld && !rd_cause) |=> (tc_q && $stable(cause_q) && $stable(seq_q)));

endmodule

// File: rtl/isr_rdport.sv
module isr_rdport
   import isr_pkg::*;
#(
   parameter int              ADDR_W   = 4,
   parameter int              DATA_W   = 8,
   parameter int              PHASE_W  = 3,
   parameter int              SEQ_W    = 3,
   parameter int              CAUSE_W  = 8,
   parameter logic [ADDR_W-1:0] OFS_STAT  = 'h4,
   parameter logic [ADDR_W-1:0] OFS_CAUSE = 'h5,
   parameter logic [ADDR_W-1:0] OFS_SEQ   = 'h6,
   parameter bit              OUT_REG  = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic               reg_rd,
   input  logic [PHASE_W-1:0] phase_q,
   input  logic               tc_q,
   input  logic [SEQ_W-1:0]   seq_q,
   input  logic [CAUSE_W-1:0] cause_q,
   output logic               rd_cause,
   output logic [DATA_W-1:0]  reg_rdata
);

   logic [7:0]        stat_byte;
   logic [DATA_W-1:0] sel_data;

   always_comb begin
      stat_byte               = '0;
      stat_byte[2:0]          = 3'(phase_q);
      stat_byte[STAT_TC_BIT]  = tc_q;
      stat_byte[STAT_INT_BIT] = |cause_q;
   end

   assign rd_cause = reg_rd && (reg_addr == OFS_CAUSE);

   always_comb begin
      if (reg_addr == OFS_STAT)       sel_data = DATA_W'(stat_byte);
      else if (reg_addr == OFS_CAUSE) sel_data = DATA_W'(cause_q);
      else if (reg_addr == OFS_SEQ)   sel_data = DATA_W'(seq_q);
      else                            sel_data = '0;
   end

   generate
      if (OUT_REG) begin : g_reg
         logic [DATA_W-1:0] rdata_q;
         always_ff @(posedge clk) begin
            if (rst)         rdata_q <= '0;
            else if (reg_rd) rdata_q <= sel_data;
         end
         assign reg_rdata = rdata_q;
      end else begin : g_comb
         assign reg_rdata = reg_rd ? sel_data : '0;
      end
   endgenerate

endmodule

// File: rtl/isr_bank.sv
module isr_bank
   import isr_pkg::*;
#(
   parameter int ADDR_W       = 4,
   parameter int DATA_W       = 8,
   parameter int PHASE_W      = 3,
   parameter int SEQ_W        = 3,
   parameter bit OUT_REG      = 1'b1,
   parameter bit DEFER_LATEST = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic               reg_rd,
   input  logic               reg_wr,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   input  logic               cmpl_valid,
   input  logic [PHASE_W-1:0] cmpl_phase,
   input  logic               tc_hit,
   output logic               irq
);

   localparam int CAUSE_W = 8;
   localparam logic [ADDR_W-1:0] OFS_STAT  = ADDR_W'(4'h4);
   localparam logic [ADDR_W-1:0] OFS_CAUSE = ADDR_W'(4'h5);
   localparam logic [ADDR_W-1:0] OFS_SEQ   = ADDR_W'(4'h6);

   generate
      if (ADDR_W < 4) begin : g_bad_addr
         $error("isr_bank: ADDR_W must be at least 4");
      end
      if (DATA_W < 8) begin : g_bad_data
         $error("isr_bank: DATA_W must be at least 8");
      end
      if (PHASE_W != 3) begin : g_bad_phase
         $error("isr_bank: PHASE_W must be 3");
      end
      if (SEQ_W < 3 || SEQ_W > DATA_W) begin : g_bad_seq
         $error("isr_bank: SEQ_W out of range");
      end
   endgenerate

   logic               apply_vld;
   logic [PHASE_W-1:0] apply_phase;
   logic               held_q;
   logic               rd_cause;
   logic [PHASE_W-1:0] phase_q;
   logic               tc_q;
   logic [SEQ_W-1:0]   seq_q;
   logic [CAUSE_W-1:0] cause_q;
   logic               pend;

   assign pend = |cause_q;
   assign irq  = pend;

   isr_defer #(
      .PHASE_W      (PHASE_W),
      .DEFER_LATEST (DEFER_LATEST)
   ) u_defer (
      .clk         (clk),
      .rst         (rst),
      .cmpl_valid  (cmpl_valid),
      .cmpl_phase  (cmpl_phase),
      .pend        (pend),
      .apply_vld   (apply_vld),
      .apply_phase (apply_phase),
      .held_q      (held_q)
   );

   isr_regs #(
      .PHASE_W (PHASE_W),
      .SEQ_W   (SEQ_W),
      .CAUSE_W (CAUSE_W)
   ) u_regs (
      .clk         (clk),
      .rst         (rst),
      .apply_vld   (apply_vld),
      .apply_phase (apply_phase),
      .rd_cause    (rd_cause),
      .tc_hit      (tc_hit),
      .phase_q     (phase_q),
      .tc_q        (tc_q),
      .seq_q       (seq_q),
      .cause_q     (cause_q)
   );

   isr_rdport #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .PHASE_W   (PHASE_W),
      .SEQ_W     (SEQ_W),
      .CAUSE_W   (CAUSE_W),
      .OFS_STAT  (OFS_STAT),
      .OFS_CAUSE (OFS_CAUSE),
      .OFS_SEQ   (OFS_SEQ),
      .OUT_REG   (OUT_REG)
   ) u_rdport (
      .clk       (clk),
      .rst       (rst),
      .reg_addr  (reg_addr),
      .reg_rd    (reg_rd),
      .phase_q   (phase_q),
      .tc_q      (tc_q),
      .seq_q     (seq_q),
      .cause_q   (cause_q),
      .rd_cause  (rd_cause),
      .reg_rdata (reg_rdata)
   );

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (cause_q == '0 && !held_q && !irq && !tc_q && seq_q == '0));

   // R10
   wr_ignore_chk: assert property (@(posedge clk) disable iff (rst)
      (reg_wr && !$isunknown(reg_wdata) && !reg_rd && !cmpl_valid && !tc_hit && !held_q)
      |=> ($stable(cause_q) && $stable(phase_q) && $stable(tc_q) && $stable(seq_q)));

endmodule

// File: tb/isr_bank_tb.sv
module isr_bank_tb;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [3:0] reg_addr = '0;
   logic       reg_rd = 1'b0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       cmpl_valid = 1'b0;
   logic [2:0] cmpl_phase = '0;
   logic       tc_hit = 1'b0;
   logic       irq;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   isr_bank u_dut (
      .clk        (clk),
      .rst        (rst),
      .reg_addr   (reg_addr),
      .reg_rd     (reg_rd),
      .reg_wr     (reg_wr),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .cmpl_valid (cmpl_valid),
      .cmpl_phase (cmpl_phase),
      .tc_hit     (tc_hit),
      .irq        (irq)
   );

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] v);
      @(negedge clk);
      reg_addr = a;
      reg_rd   = 1'b1;
      @(negedge clk);
      reg_rd = 1'b0;
      v = reg_rdata;
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr  = a;
      reg_wdata = d;
      reg_wr    = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic cmpl(input logic [2:0] ph);
      @(negedge clk);
      cmpl_valid = 1'b1;
      cmpl_phase = ph;
      @(negedge clk);
      cmpl_valid = 1'b0;
   endtask

   task automatic t_reset();
      logic [7:0] v;
      do_reset();
      chk("R1 irq", irq, 0);
      rd(4'h4, v); chk("R1 status", v, 8'h00);
      rd(4'h6, v); chk("R1 seq", v, 8'h00);
      rd(4'h5, v); chk("R1 cause", v, 8'h00);
   endtask

   task automatic t_basic();
      logic [7:0] v;
      cmpl(3'd3);
      chk("R3 irq high", irq, 1);
      rd(4'h4, v); chk("R2 status", v, 8'h93);
      rd(4'h6, v); chk("R2 seq", v, 8'h00);
      rd(4'h5, v); chk("R4 cause value", v, 8'h10);
      chk("R3 irq low after ack", irq, 0);
      rd(4'h4, v); chk("R4 status after ack", v, 8'h03);
      rd(4'h6, v); chk("R4 seq after ack", v, 8'h04);
      rd(4'h5, v); chk("R4 cause cleared", v, 8'h00);
   endtask

   task automatic t_phase();
      logic [7:0] v;
      cmpl(3'd6);
      rd(4'h4, v); chk("R2 status msg-out", v, 8'h96);
      rd(4'h5, v); chk("R4 cause", v, 8'h10);
      rd(4'h4, v); chk("R3 status no int", v, 8'h06);
   endtask

   task automatic t_tc();
      logic [7:0] v;
      @(negedge clk); tc_hit = 1'b1;
      @(negedge clk); tc_hit = 1'b0;
      chk("R8 irq unchanged", irq, 0);
      rd(4'h4, v); chk("R8 status tc", v, 8'h16);
      rd(4'h6, v); chk("R8 seq unchanged", v, 8'h04);
      rd(4'h5, v); chk("R8 cause unchanged", v, 8'h00);
   endtask

   task automatic t_defer();
      logic [7:0] v;
      cmpl(3'd3);
      rd(4'h4, v); chk("R5 status first event", v, 8'h93);
      cmpl(3'd7);
      chk("R5 irq held", irq, 1);
      rd(4'h6, v); chk("R5 seq first event", v, 8'h00);
      rd(4'h5, v); chk("R5 cause first event", v, 8'h10);
      chk("R6 irq low right after ack", irq, 0);
      @(negedge clk);
      chk("R6 irq raised again", irq, 1);
      rd(4'h4, v); chk("R6 status second event", v, 8'h97);
      rd(4'h6, v); chk("R6 seq second event", v, 8'h00);
      rd(4'h5, v); chk("R6 cause second event", v, 8'h10);
      @(negedge clk);
      @(negedge clk);
      chk("R6 applied once", irq, 0);
   endtask

   task automatic t_latest();
      logic [7:0] v;
      cmpl(3'd1);
      cmpl(3'd6);
      cmpl(3'd0);
      rd(4'h5, v); chk("R7 first cause", v, 8'h10);
      @(negedge clk);
      rd(4'h4, v); chk("R7 latest phase kept", v, 8'h90);
      rd(4'h5, v);
   endtask

   task automatic t_same_edge();
      logic [7:0] v;
      cmpl(3'd2);
      @(negedge clk);
      reg_addr   = 4'h5;
      reg_rd     = 1'b1;
      cmpl_valid = 1'b1;
      cmpl_phase = 3'd7;
      @(negedge clk);
      reg_rd     = 1'b0;
      cmpl_valid = 1'b0;
      chk("R11 read returns old cause", reg_rdata, 8'h10);
      chk("R11 irq low after ack", irq, 0);
      @(negedge clk);
      chk("R11 irq after held apply", irq, 1);
      rd(4'h4, v); chk("R11 status new event", v, 8'h97);
      rd(4'h5, v);
   endtask

   task automatic t_ignore();
      logic [7:0] v;
      cmpl(3'd3);
      wr(4'h4, 8'hFF);
      wr(4'h5, 8'h00);
      wr(4'h6, 8'hFF);
      chk("R10 irq after writes", irq, 1);
      rd(4'h4, v); chk("R10 status after writes", v, 8'h93);
      rd(4'h4, v); chk("R9 status reread", v, 8'h93);
      rd(4'h6, v); chk("R10 seq after writes", v, 8'h00);
      rd(4'h3, v); chk("R9 other offset zero", v, 8'h00);
      rd(4'hE, v); chk("R9 high offset zero", v, 8'h00);
      chk("R9 irq after side reads", irq, 1);
      rd(4'h5, v); chk("R9 cause kept", v, 8'h10);
   endtask

   task automatic t_reset_held();
      logic [7:0] v;
      cmpl(3'd3);
      cmpl(3'd6);
      do_reset();
      chk("R1 irq after reset", irq, 0);
      @(negedge clk);
      @(negedge clk);
      chk("R1 held dropped", irq, 0);
      rd(4'h4, v); chk("R1 status after reset", v, 8'h00);
      rd(4'h5, v); chk("R1 cause after reset", v, 8'h00);
      @(negedge clk);
      chk("R1 no late apply", irq, 0);
   endtask

   initial begin
      t_reset();
      t_basic();
      t_phase();
      t_tc();
      t_defer();
      t_latest();
      t_same_edge();
      t_ignore();
      t_reset_held();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule